// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block chooses which of three clocks drives the machine clock: the main oscillator, the PLL-multiplied clock or the slow sub-clock. Software holds two request levels. One chooses between main and PLL. The other chooses between the main/PLL side and the sub-clock. Software also writes a 3-bit multiplier code. The block orders each change of source and inserts the waits the change needs. It reports the source actually in use through two status bits. Software polls these bits before it relies on the new clock.

Entering the sub-clock takes effect at once. Leaving it waits a main-oscillator stabilization interval, which is counted in ticks of a slow reference. A move onto the PLL also waits for the lock input. While a wait is running, changes to the requests are not acted on. When the wait ends, the block compares the requests with the new source. The one-hot source select and the multiplier factor feed a downstream clock multiplexer.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, src_sel_o is 3'b001 (main), stat_mp_o and stat_ms_o are both 1, mult_o is 1 and err_o is 0.
- R2: The target source is sub when req_ms_i is 0, regardless of req_mp_i. It is PLL when req_ms_i is 1 and req_mp_i is 0. It is main when both are 1.
- R3: A switch to sub, from main or from PLL, appears on the outputs one clock after the request is sampled, with no wait.
- R4: Leaving sub for main keeps src_sel_o at sub until 2^STAB_LOG2 cycles with ref_tick_i high have passed in the wait. The switch happens on the edge that samples the last such tick.
- R5: Main to PLL keeps main selected until pll_lock_i is sampled high in the lock-wait phase. The phase is entered on the first edge after the request, and the switch happens on the edge that samples lock high. PLL to main takes one clock.
- R6: Leaving sub for PLL runs the full stabilization wait first, then the lock wait. The source stays sub throughout both waits.
- R7: Request changes during a wait are ignored. When the wait ends, the block moves to the latched target. On the next edge it re-evaluates the requests against the new source.
- R8: A write (mult_wr_i high) of mult_code_i sets mult_o as follows: 000→1, 001→2, 010→3, 011→4, 110→6.
- R9: A write of code 100, 101 or 111 leaves mult_o unchanged and sets err_o. err_o stays set until reset.
- R10: src_sel_o is one-hot: bit 0 is main, bit 1 is PLL and bit 2 is sub. stat_mp_o is 0 only while PLL is in use. stat_ms_o is 0 only while sub is in use.
- R11: ref_tick_i has no effect outside a stabilization wait. Inside a wait, only cycles with ref_tick_i high advance the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_mp_i | input | 1 | Request: 1 = main, 0 = PLL |
| req_ms_i | input | 1 | Request: 1 = main/PLL side, 0 = sub-clock |
| mult_wr_i | input | 1 | Strobe that loads mult_code_i |
| mult_code_i | input | 3 | PLL multiplier code |
| pll_lock_i | input | 1 | PLL locked indication |
| ref_tick_i | input | 1 | Stabilization reference tick enable |
| src_sel_o | output | 3 | One-hot source select (main, PLL, sub) |
| mult_o | output | 3 | Multiplier factor value |
| stat_mp_o | output | 1 | 0 while PLL is in use |
| stat_ms_o | output | 1 | 0 while sub-clock is in use |
| err_o | output | 1 | Sticky invalid-code flag |

## Verification
The bench changes inputs on falling edges and reads outputs on the next falling edge, so each registered result is read one edge after the edge that produces it. An immediate switch and a multiplier write are due one cycle after the stimulus. A lock-gated switch is due one cycle after lock rises, or two cycles after the request if lock is already high. A stabilization exit with the reference tick held high is due after 2^STAB_LOG2 + 1 cycles. The bench checks the old source one cycle before each due edge and the new source on the due edge. For the multiplier, the bench computes the expected factor and the expected sticky flag for every code.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_SUB  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OSC  = 2'd1,
    PH_LOCK = 2'd2
  } phase_e;

  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned FAC_W   = 3;

  typedef struct packed {
    logic             ok;
    logic [FAC_W-1:0] fac;
  } mult_t;

  function automatic mult_t mult_lookup(input logic [CODE_W-1:0] code);
    mult_t r;
    r.ok = 1'b1;
    case (code)
      3'b000:  r.fac = FAC_W'(1);
      3'b001:  r.fac = FAC_W'(2);
      3'b010:  r.fac = FAC_W'(3);
      3'b011:  r.fac = FAC_W'(4);
      3'b110:  r.fac = FAC_W'(6);
      default: begin
        r.ok  = 1'b0;
        r.fac = FAC_W'(1);
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clk_req_decode.sv
module clk_req_decode
  import clk_mode_pkg::*;
(
  input  logic req_mp_i,
  input  logic req_ms_i,
  output src_e tgt_o
);
  // sub request outranks PLL request
  always_comb begin
    if (!req_ms_i)      tgt_o = SRC_SUB;
    else if (!req_mp_i) tgt_o = SRC_PLL;
    else                tgt_o = SRC_MAIN;
  end
endmodule

// File: rtl/clk_stab_timer.sv
module clk_stab_timer #(
  parameter int unsigned LOG2 = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  logic [LOG2-1:0] cnt_q;
  logic            last;

  assign last   = (cnt_q == {LOG2{1'b1}});
  assign done_o = run_i & tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_mult_reg.sv
module clk_mult_reg
  import clk_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [FAC_W-1:0]  fac_o,
  output logic              err_o
);
  mult_t lk;
  assign lk = mult_lookup(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fac_o <= FAC_W'(1);
      err_o <= 1'b0;
    end else if (wr_i) begin
      if (lk.ok) fac_o <= lk.fac;
      else       err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int unsigned STAB_LOG2 = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_mp_i,
  input  logic               req_ms_i,
  input  logic               mult_wr_i,
  input  logic [CODE_W-1:0]  mult_code_i,
  input  logic               pll_lock_i,
  input  logic               ref_tick_i,
  output logic [NUM_SRC-1:0] src_sel_o,
  output logic [FAC_W-1:0]   mult_o,
  output logic               stat_mp_o,
  output logic               stat_ms_o,
  output logic               err_o
);
  src_e   src_q, tgt_q, req_tgt;
  phase_e phase_q;
  logic   stab_done;

  clk_req_decode u_dec (
    .req_mp_i (req_mp_i),
    .req_ms_i (req_ms_i),
    .tgt_o    (req_tgt)
  );

  clk_stab_timer #(.LOG2(STAB_LOG2)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (phase_q == PH_IDLE),
    .run_i   (phase_q == PH_OSC),
    .tick_i  (ref_tick_i),
    .done_o  (stab_done)
  );

  clk_mult_reg u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (mult_wr_i),
    .code_i (mult_code_i),
    .fac_o  (mult_o),
    .err_o  (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= SRC_MAIN;
      tgt_q   <= SRC_MAIN;
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_tgt != src_q) begin
          tgt_q <= req_tgt;
          if (src_q == SRC_SUB)       phase_q <= PH_OSC;
          else if (req_tgt == SRC_PLL) phase_q <= PH_LOCK;
          else                         src_q   <= req_tgt;
        end
        PH_OSC: if (stab_done) begin
          if (tgt_q == SRC_PLL) phase_q <= PH_LOCK;
          else begin
            src_q   <= SRC_MAIN;
            phase_q <= PH_IDLE;
          end
        end
        PH_LOCK: if (pll_lock_i) begin
          src_q   <= SRC_PLL;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    assign src_sel_o[g] = (src_q == src_e'(g));
  end

  assign stat_mp_o = (src_q != SRC_PLL);
  assign stat_ms_o = (src_q != SRC_SUB);
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ms_i,
  input logic       mult_wr_i,
  input logic [2:0] mult_code_i,
  input logic       pll_lock_i,
  input logic       stab_done_i,
  input logic [2:0] src_sel_o,
  input logic [2:0] mult_o,
  input logic       err_o
);
  assert_onehot_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(src_sel_o));

  assert_pll_to_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_o[1] && !req_ms_i) |=> src_sel_o[2]);

  assert_sub_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(src_sel_o[2]) |-> (src_sel_o[0] ? $past(stab_done_i) : $past(pll_lock_i)));

  assert_pll_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_sel_o[1]) |-> $past(pll_lock_i));

  assert_mult_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_o inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6});

  assert_bad_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mult_wr_i && (mult_code_i inside {3'd4, 3'd5, 3'd7})) |=> ($stable(mult_o) && err_o));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ms_i    (req_ms_i),
  .mult_wr_i   (mult_wr_i),
  .mult_code_i (mult_code_i),
  .pll_lock_i  (pll_lock_i),
  .stab_done_i (stab_done),
  .src_sel_o   (src_sel_o),
  .mult_o      (mult_o),
  .err_o       (err_o)
);

// File: tb/tb_clk_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clk_mode_ctrl;
  localparam int unsigned LOG2 = 3;
  localparam int unsigned WAIT = 1 << LOG2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_mp = 1'b1, req_ms = 1'b1, wr = 1'b0, lock = 1'b0, tick = 1'b0;
  logic [2:0] code = '0;
  logic [2:0] sel, mult;
  logic       smp, sms, err;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  clk_mode_ctrl #(.STAB_LOG2(LOG2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_mp_i(req_mp), .req_ms_i(req_ms),
    .mult_wr_i(wr), .mult_code_i(code), .pll_lock_i(lock), .ref_tick_i(tick),
    .src_sel_o(sel), .mult_o(mult), .stat_mp_o(smp), .stat_ms_o(sms), .err_o(err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sel bit0 main, bit1 PLL, bit2 sub; status {mp,ms}
  task automatic chk_src(input string tag, input logic [2:0] exp_sel);
    chk(tag, {3'b0, sel, smp, sms}, {3'b0, exp_sel, ~exp_sel[1], ~exp_sel[2]});
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk_src("R1 reset source", 3'b001);
    chk("R1 reset mult", {5'b0, mult}, 8'd1);
    chk("R1 reset err", {7'b0, err}, 8'd0);

    begin
      logic [2:0] exp_f = 3'd1;
      logic       exp_e = 1'b0;
      for (int c = 0; c < 8; c++) begin
        code = 3'(c); wr = 1'b1;
        step(1); wr = 1'b0;
        if (c < 4) exp_f = 3'(c + 1);
        else if (c == 6) exp_f = 3'd6;
        else exp_e = 1'b1;
        chk((c inside {4, 5, 7}) ? "R9 invalid code keeps factor" : "R8 code factor",
            {5'b0, mult}, {5'b0, exp_f});
        chk("R9 error flag", {7'b0, err}, {7'b0, exp_e});
      end
      code = 3'd0; wr = 1'b1; step(1); wr = 1'b0;
      chk("R8 back to x1", {5'b0, mult}, 8'd1);
      chk("R9 err sticky", {7'b0, err}, 8'd1);
    end

    tick = 1'b1; step(20);
    chk_src("R11 idle ticks no effect", 3'b001);
    req_ms = 1'b0; step(1);
    chk_src("R3 main to sub immediate", 3'b100);

    req_ms = 1'b1; step(WAIT);
    chk_src("R4 sub held during wait", 3'b100);
    step(1);
    chk_src("R4 main after wait", 3'b001);

    tick = 1'b0; req_mp = 1'b0; step(5);
    chk_src("R5 main held until lock", 3'b001);
    lock = 1'b1; step(1);
    chk_src("R5 pll after lock", 3'b010);
    req_mp = 1'b1; step(1);
    chk_src("R5 pll to main immediate", 3'b001);
    req_mp = 1'b0; step(1);
    chk_src("R5 lock phase cycle", 3'b001);
    step(1);
    chk_src("R5 pll with lock high", 3'b010);

    req_ms = 1'b0; step(1);
    chk_src("R2 sub wins over pll, R3 pll to sub", 3'b100);

    lock = 1'b0; tick = 1'b1; req_ms = 1'b1; step(WAIT + 1);
    chk_src("R6 sub held after wait until lock", 3'b100);
    lock = 1'b1; step(1);
    chk_src("R6 pll after wait and lock", 3'b010);

    req_ms = 1'b0; step(1);
    chk_src("R3 to sub", 3'b100);
    req_mp = 1'b1; req_ms = 1'b1; step(4);
    req_ms = 1'b0; step(WAIT - 4);
    chk_src("R7 mid-wait request ignored", 3'b100);
    step(1);
    chk_src("R7 wait completes to main", 3'b001);
    step(1);
    chk_src("R7 re-evaluated to sub", 3'b100);

    tick = 1'b0; req_ms = 1'b1; step(20);
    chk_src("R11 no ticks no progress", 3'b100);
    tick = 1'b1; step(WAIT - 1);
    chk_src("R11 one tick short", 3'b100);
    step(1);
    chk_src("R11 main after ticks", 3'b001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule